// File: doc/BRIEF.md
# Host-to-PCI Bridge Window Register File and Address Translator

This block sits beside a host-to-PCI bridge. It keeps eight 32-bit control registers: three inbound map words, three outbound map words, a bridge identity word and a flags word. Software reaches them through a request/response register port. Only the three inbound map words act on the datapath. Each one sets where its system memory window lands in PCI memory space.

The address side takes one window hit at a time: a window number and the system address that hit it. It returns the PCI memory address one cycle later. The rule used for the translation is fixed at build time by the `VARIANT` parameter. Variant 0 places the map word's low nibble on the top four address bits. Variant 1 clears the map word's bits below the window size and adds the offset. Each variant has its own window bases and sizes. Protocol conversion and the PCI transactions themselves belong to other blocks.

Both interfaces are valid/ready. A request is accepted on a clock edge where valid and ready are both high. The block raises the matching response one cycle after acceptance and holds it, unchanged, until the consumer's ready is high. Ready toward the requester is low only while a response is waiting and the consumer's ready is low. So a stalled consumer stalls its own requester and nothing else.

Top module: `pcib_window_ctl`

## Requirements
- R1: After reset, every register reads as 0, and no register response or translated address is valid.
- R2: The register word offsets are: inbound maps 0, 1, 2 at 0x00, 0x04, 0x08; identity at 0x0C; flags at 0x10; outbound maps 0, 1, 2 at 0x14, 0x18, 0x1C. A full write to any of them reads back unchanged.
- R3: A request whose byte enables are not all four set (`reg_req_be` != 4'hF) is a partial access. A partial write changes nothing, and a partial read returns 0.
- R4: A request to any offset other than the eight above changes nothing, and a read returns 0. This covers offsets above 0x1C and offsets whose two low bits are not zero.
- R5: Every accepted register request, read or write, gets exactly one response one cycle later; a write's response carries data 0. The response is held stable while `reg_rsp_ready` is low. `reg_req_ready` equals NOT `reg_rsp_valid` OR `reg_rsp_ready`.
- R6: Variant 0: PCI address = (map[3:0] << 28) + (system address − window base).
- R7: Variant 1: PCI address = (map AND NOT (window size − 1)) + (system address − window base).
- R8: Window geometry. Variant 0 has bases 0x44000000, 0x50000000, 0x60000000 and sizes 0x0C000000, 0x10000000, 0x10000000. Variant 1 has bases 0x63000000, 0x64000000, 0x68000000 and sizes 0x01000000, 0x04000000, 0x08000000. Both the first and last words of a window translate correctly.
- R9: A map write accepted on one edge is used by every translation accepted on a later edge. A translation accepted on the same edge uses the old value.
- R10: A translation accepted on one edge appears on `xl_out_addr` after that edge, and stays stable while `xl_out_ready` is low. `xl_in_ready` equals NOT `xl_out_valid` OR `xl_out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req_valid | input | 1 | Register request present |
| reg_req_ready | output | 1 | Register request can be accepted |
| reg_req_write | input | 1 | 1 = write, 0 = read |
| reg_req_addr | input | ADDR_W | Byte offset of the register |
| reg_req_be | input | 4 | Byte enables; only 4'hF is a valid access |
| reg_req_wdata | input | 32 | Write data |
| reg_rsp_valid | output | 1 | Register response present |
| reg_rsp_ready | input | 1 | Consumer takes the response |
| reg_rsp_rdata | output | 32 | Read data (0 for writes and rejected reads) |
| xl_in_valid | input | 1 | Window hit present |
| xl_in_ready | output | 1 | Window hit can be accepted |
| xl_in_win | input | 2 | Window number 0..2 |
| xl_in_addr | input | 32 | System address inside that window |
| xl_out_valid | output | 1 | Translated address present |
| xl_out_ready | input | 1 | Consumer takes the translated address |
| xl_out_addr | output | 32 | PCI memory address |

## Verification
The assertions assume that a window hit always names window 0, 1 or 2. They also assume that its system address lies between that window's base and base plus size for the built variant. Neither case is given a meaning of its own. The stimulus follows both assumptions by building every translation address as a window base plus an offset drawn below that window's size. The two bench instances, one per variant, each get addresses from their own window table. Register stimulus is free to use unmapped and misaligned offsets and partial byte enables. Those inputs have defined behaviour.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  localparam int DW     = 32;
  localparam int NWIN   = 3;
  localparam int NREG   = 8;
  localparam int WSEL_W = $clog2(NWIN);

  typedef logic [DW-1:0] word_t;

  // window geometry per build variant; base and size in bytes
  function automatic word_t win_base(int variant, int w);
    if (variant == 0) begin
      case (w)
        0:       return 32'h4400_0000;
        1:       return 32'h5000_0000;
        default: return 32'h6000_0000;
      endcase
    end
    case (w)
      0:       return 32'h6300_0000;
      1:       return 32'h6400_0000;
      default: return 32'h6800_0000;
    endcase
  endfunction

  function automatic word_t win_size(int variant, int w);
    if (variant == 0) begin
      case (w)
        0:       return 32'h0C00_0000;
        default: return 32'h1000_0000;
      endcase
    end
    case (w)
      0:       return 32'h0100_0000;
      1:       return 32'h0400_0000;
      default: return 32'h0800_0000;
    endcase
  endfunction
endpackage

// File: rtl/pcib_regfile.sv
module pcib_regfile
  import pcib_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [3:0]             req_be,
  input  word_t                  req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output word_t                  rsp_rdata,
  output logic [NWIN-1:0][DW-1:0] imap_o
);
  localparam int IW = $clog2(NREG);

  word_t          regs [NREG];
  logic           fire, hit, full, ok;
  logic [IW-1:0]  idx;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign idx       = req_addr[IW+1:2];
  assign hit       = (req_addr[ADDR_W-1:IW+2] == '0) && (req_addr[1:0] == 2'b00);
  assign full      = &req_be;
  assign ok        = hit && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire) begin
      if (req_write && ok) regs[idx] <= req_wdata;
      rsp_valid <= 1'b1;
      rsp_rdata <= (!req_write && ok) ? regs[idx] : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_imap
    assign imap_o[w] = regs[w];
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);                                   // R5
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));            // R5
  AST_PARTIAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && !(&req_be) |=> $stable(imap_o));  // R3
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && (req_addr[1:0] != 2'b00)
    |=> $stable(imap_o));                                                    // R4
endmodule

// File: rtl/pcib_xlate.sv
module pcib_xlate
  import pcib_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NWIN-1:0][DW-1:0] imap_i,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WSEL_W-1:0]       in_win,
  input  word_t                   in_addr,
  output logic                    out_valid,
  input  logic                    out_ready,
  output word_t                   out_addr
);
  logic [NWIN-1:0][DW-1:0] cand;
  logic [NWIN-1:0]         inrng;
  word_t                   sel;
  logic                    sel_inrng, fire;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam word_t BASE = win_base(VARIANT, w);
    localparam word_t SIZE = win_size(VARIANT, w);
    word_t off;
    assign off      = in_addr - BASE;
    assign inrng[w] = (in_addr >= BASE) && (off < SIZE);
    if (VARIANT == 0) begin : g_nibble
      logic unused_hi;
      assign unused_hi = ^imap_i[w][DW-1:4];
      assign cand[w]   = {imap_i[w][3:0], {(DW-4){1'b0}}} + off;
    end else begin : g_masked
      assign cand[w] = (imap_i[w] & ~(SIZE - 1)) + off;
    end
  end

  always_comb begin
    sel       = '0;
    sel_inrng = 1'b0;
    for (int w = 0; w < NWIN; w++) begin
      if (in_win == w[WSEL_W-1:0]) begin
        sel       = cand[w];
        sel_inrng = inrng[w];
      end
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_addr  <= sel;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_WIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_win < WSEL_W'(NWIN)));                                  // R8
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> sel_inrng);                                                 // R8
  AST_XL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));             // R10
  AST_XL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);                                     // R10
endmodule

// File: rtl/pcib_window_ctl.sv
module pcib_window_ctl
  import pcib_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req_valid,
  output logic              reg_req_ready,
  input  logic              reg_req_write,
  input  logic [ADDR_W-1:0] reg_req_addr,
  input  logic [3:0]        reg_req_be,
  input  logic [31:0]       reg_req_wdata,
  output logic              reg_rsp_valid,
  input  logic              reg_rsp_ready,
  output logic [31:0]       reg_rsp_rdata,
  input  logic              xl_in_valid,
  output logic              xl_in_ready,
  input  logic [1:0]        xl_in_win,
  input  logic [31:0]       xl_in_addr,
  output logic              xl_out_valid,
  input  logic              xl_out_ready,
  output logic [31:0]       xl_out_addr
);
  logic [NWIN-1:0][DW-1:0] imap;

  pcib_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (reg_req_valid),
    .req_ready (reg_req_ready),
    .req_write (reg_req_write),
    .req_addr  (reg_req_addr),
    .req_be    (reg_req_be),
    .req_wdata (reg_req_wdata),
    .rsp_valid (reg_rsp_valid),
    .rsp_ready (reg_rsp_ready),
    .rsp_rdata (reg_rsp_rdata),
    .imap_o    (imap)
  );

  pcib_xlate #(.VARIANT(VARIANT)) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .imap_i    (imap),
    .in_valid  (xl_in_valid),
    .in_ready  (xl_in_ready),
    .in_win    (xl_in_win),
    .in_addr   (xl_in_addr),
    .out_valid (xl_out_valid),
    .out_ready (xl_out_ready),
    .out_addr  (xl_out_addr)
  );
endmodule

// File: tb/tb_pcib_window_ctl.sv
module tb_pcib_window_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  localparam int unsigned T_BASE [2][3] = '{'{32'h4400_0000, 32'h5000_0000, 32'h6000_0000},
                                            '{32'h6300_0000, 32'h6400_0000, 32'h6800_0000}};
  localparam int unsigned T_SIZE [2][3] = '{'{32'h0C00_0000, 32'h1000_0000, 32'h1000_0000},
                                            '{32'h0100_0000, 32'h0400_0000, 32'h0800_0000}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic xl_valid = 0, xl_oready = 1;
  logic [1:0] xl_win = '0;
  logic [31:0] xa0 = '0, xa1 = '0;

  logic req_ready0, rsp_valid0, xi_ready0, xo_valid0;
  logic req_ready1, rsp_valid1, xi_ready1, xo_valid1;
  logic [31:0] rdata0, rdata1, xo_addr0, xo_addr1;

  int tests = 0, fails = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcib_window_ctl #(.VARIANT(0), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_req_valid(req_valid), .reg_req_ready(req_ready0), .reg_req_write(req_write),
    .reg_req_addr(req_addr), .reg_req_be(req_be), .reg_req_wdata(req_wdata),
    .reg_rsp_valid(rsp_valid0), .reg_rsp_ready(rsp_ready), .reg_rsp_rdata(rdata0),
    .xl_in_valid(xl_valid), .xl_in_ready(xi_ready0), .xl_in_win(xl_win), .xl_in_addr(xa0),
    .xl_out_valid(xo_valid0), .xl_out_ready(xl_oready), .xl_out_addr(xo_addr0));

  pcib_window_ctl #(.VARIANT(1), .ADDR_W(AW)) dut_v1 (
    .clk(clk), .rst_n(rst_n),
    .reg_req_valid(req_valid), .reg_req_ready(req_ready1), .reg_req_write(req_write),
    .reg_req_addr(req_addr), .reg_req_be(req_be), .reg_req_wdata(req_wdata),
    .reg_rsp_valid(rsp_valid1), .reg_rsp_ready(rsp_ready), .reg_rsp_rdata(rdata1),
    .xl_in_valid(xl_valid), .xl_in_ready(xi_ready1), .xl_in_win(xl_win), .xl_in_addr(xa1),
    .xl_out_valid(xo_valid1), .xl_out_ready(xl_oready), .xl_out_addr(xo_addr1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int unsigned ref_xl(int v, int w, int unsigned a, int unsigned map);
    int unsigned off = a - T_BASE[v][w];
    if (v == 0) return ((map & 32'hF) << 28) + off;
    return (map & ~(T_SIZE[v][w] - 1)) + off;
  endfunction

  // behavioural reference model, advanced on each rising edge
  int unsigned mreg [8];
  bit m_rsp_v, m_xo_v;
  int unsigned m_rsp_d, m_xo_a0, m_xo_a1;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mreg[i]) mreg[i] = 0;
      m_rsp_v = 0; m_rsp_d = 0; m_xo_v = 0; m_xo_a0 = 0; m_xo_a1 = 0;
    end else begin
      if (xl_valid && (!m_xo_v || xl_oready)) begin
        m_xo_v  = 1;
        m_xo_a0 = ref_xl(0, xl_win, xa0, mreg[xl_win]);
        m_xo_a1 = ref_xl(1, xl_win, xa1, mreg[xl_win]);
      end else if (xl_oready) m_xo_v = 0;
      if (req_valid && (!m_rsp_v || rsp_ready)) begin
        bit okr;
        okr = (req_addr % 4 == 0) && (req_addr < 32) && (req_be == 4'hF);
        m_rsp_d = (!req_write && okr) ? mreg[req_addr / 4] : 0;
        if (req_write && okr) mreg[req_addr / 4] = req_wdata;
        m_rsp_v = 1;
      end else if (rsp_ready) m_rsp_v = 0;
    end
    started = 1;
  end

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (started && rst_n) begin
      check("R5 req_ready v0", req_ready0, !m_rsp_v || rsp_ready);
      check("R5 req_ready v1", req_ready1, !m_rsp_v || rsp_ready);
      check("R5 rsp_valid v0", rsp_valid0, m_rsp_v);
      check("R5 rsp_valid v1", rsp_valid1, m_rsp_v);
      if (m_rsp_v) begin
        check("R2 rsp_rdata v0", rdata0, m_rsp_d);
        check("R2 rsp_rdata v1", rdata1, m_rsp_d);
      end
      check("R10 xl_in_ready", xi_ready0 & xi_ready1, !m_xo_v || xl_oready);
      check("R10 xl_out_valid", xo_valid0 & xo_valid1, m_xo_v);
      if (m_xo_v) begin
        check("R6 xl_out_addr v0", xo_addr0, m_xo_a0);
        check("R7 xl_out_addr v1", xo_addr1, m_xo_a1);
      end
    end
  end

  task automatic reg_op(input bit wr, input logic [AW-1:0] a, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] r0, output logic [31:0] r1);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    r0 = rdata0; r1 = rdata1;
  endtask

  task automatic xl_op(input logic [1:0] w, input logic [31:0] a0, input logic [31:0] a1,
                       output logic [31:0] o0, output logic [31:0] o1);
    @(negedge clk);
    xl_valid = 1; xl_win = w; xa0 = a0; xa1 = a1;
    @(negedge clk);
    xl_valid = 0;
    o0 = xo_addr0; o1 = xo_addr1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r0, r1, o0, o1;
    logic [31:0] pat [8];
    repeat (3) @(negedge clk);
    check("R1 rsp_valid after reset", rsp_valid0 | rsp_valid1, 0);
    check("R1 xl_out_valid after reset", xo_valid0 | xo_valid1, 0);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      reg_op(0, AW'(i * 4), 4'hF, 0, r0, r1);
      check("R1 register reset value", r0 | r1, 0);
    end
    // R2 write every register with a distinct pattern and read back
    for (int i = 0; i < 8; i++) begin
      pat[i] = 32'hC0DE_0000 + 32'(i * 32'h1111);
      reg_op(1, AW'(i * 4), 4'hF, pat[i], r0, r1);
      check("R5 write response data", r0 | r1, 0);
    end
    for (int i = 0; i < 8; i++) begin
      reg_op(0, AW'(i * 4), 4'hF, 0, r0, r1);
      check("R2 readback v0", r0, pat[i]);
      check("R2 readback v1", r1, pat[i]);
    end
    // R3 partial accesses
    reg_op(1, 12'h004, 4'h3, 32'hDEAD_BEEF, r0, r1);
    reg_op(0, 12'h004, 4'h1, 0, r0, r1);
    check("R3 partial read returns 0", r0 | r1, 0);
    reg_op(0, 12'h004, 4'hF, 0, r0, r1);
    check("R3 partial write ignored", r0, pat[1]);
    // R4 unmapped and misaligned
    reg_op(1, 12'h020, 4'hF, 32'h1111_2222, r0, r1);
    reg_op(1, 12'h002, 4'hF, 32'h3333_4444, r0, r1);
    reg_op(0, 12'h020, 4'hF, 0, r0, r1);
    check("R4 unmapped read 0x020", r0 | r1, 0);
    reg_op(0, 12'hFFC, 4'hF, 0, r0, r1);
    check("R4 unmapped read 0xFFC", r0 | r1, 0);
    reg_op(0, 12'h001, 4'hF, 0, r0, r1);
    check("R4 misaligned read", r0 | r1, 0);
    reg_op(0, 12'h000, 4'hF, 0, r0, r1);
    check("R4 misaligned write ignored", r0, pat[0]);
    // program map words for translation
    reg_op(1, 12'h000, 4'hF, 32'h1234_5675, r0, r1);
    reg_op(1, 12'h004, 4'hF, 32'hABCD_EF0A, r0, r1);
    reg_op(1, 12'h008, 4'hF, 32'h8765_4323, r0, r1);
    xl_op(0, 32'h4400_0010, 32'h6300_0010, o0, o1);
    check("R6 win0 nibble", o0, 32'h5000_0010);
    check("R7 win0 masked", o1, 32'h1200_0010);
    xl_op(1, 32'h5FFF_FFFC, 32'h67FF_FFFC, o0, o1);
    check("R8 win1 last word v0", o0, 32'hAFFF_FFFC);
    check("R8 win1 last word v1", o1, 32'hABFF_FFFC);
    xl_op(2, 32'h6000_0000, 32'h6800_0000, o0, o1);
    check("R8 win2 first word v0", o0, 32'h3000_0000);
    check("R8 win2 first word v1", o1, 32'h8000_0000);
    xl_op(0, 32'h4FFF_FFFC, 32'h63FF_FFFC, o0, o1);
    check("R8 win0 last word v0", o0, 32'h5BFF_FFFC);
    check("R8 win0 last word v1", o1, 32'h12FF_FFFC);
    // R9 same-edge translation sees old map, next one sees new map
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 12'h008; req_be = 4'hF; req_wdata = 32'h1800_0009;
    xl_valid = 1; xl_win = 2; xa0 = 32'h6000_0100; xa1 = 32'h6800_0100;
    @(negedge clk);
    req_valid = 0;
    check("R9 same edge old map v0", xo_addr0, 32'h3000_0100);
    check("R9 same edge old map v1", xo_addr1, 32'h8000_0100);
    @(negedge clk);
    xl_valid = 0;
    check("R9 next edge new map v0", xo_addr0, 32'h9000_0100);
    check("R9 next edge new map v1", xo_addr1, 32'h1800_0100);
    // R5 response back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 12'h00C; req_be = 4'hF;
    @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      check("R5 held response", rdata0, pat[3]);
      check("R5 ready low while stalled", req_ready0, 0);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    // R10 translation back-pressure
    @(negedge clk);
    xl_oready = 0; xl_valid = 1; xl_win = 1; xa0 = 32'h5000_0040; xa1 = 32'h6400_0040;
    @(negedge clk);
    xa0 = 32'h5000_0080; xa1 = 32'h6400_0080;
    repeat (3) begin
      @(negedge clk);
      check("R10 held translation v0", xo_addr0, 32'hA000_0040);
      check("R10 held translation v1", xo_addr1, 32'hA800_0040);
      check("R10 in_ready low while stalled", xi_ready0, 0);
    end
    xl_oready = 1;
    @(negedge clk);
    xl_valid = 0;
    // random traffic checked against the reference model every cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (!req_valid || req_ready0) begin
        int k = $urandom % 16;
        req_valid = ($urandom % 3) != 0;
        req_write = $urandom % 2;
        req_addr  = (k < 12) ? AW'((k % 8) * 4) : (k == 12 ? 12'h024 : (k == 13 ? 12'h003 : 12'h7F0));
        req_be    = ($urandom % 5 == 0) ? 4'($urandom) : 4'hF;
        req_wdata = $urandom;
      end
      if (!xl_valid || xi_ready0) begin
        int w = $urandom % 3;
        xl_valid = ($urandom % 3) != 0;
        xl_win = 2'(w);
        xa0 = T_BASE[0][w] + (($urandom % T_SIZE[0][w]) & ~32'h3);
        xa1 = T_BASE[1][w] + (($urandom % T_SIZE[1][w]) & ~32'h3);
      end
      rsp_ready = ($urandom % 4) != 0;
      xl_oready = ($urandom % 4) != 0;
    end
    @(negedge clk);
    req_valid = 0; xl_valid = 0; rsp_ready = 1; xl_oready = 1;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule